// File: doc/BRIEF.md
# Barrel Thread Program-Counter Sequencer

This block keeps one program counter per hardware thread of a fine-grained multithreaded core. On every clock it picks the next runnable thread in rotation. It presents that thread's number and PC to the shared fetch stage. The execution pipeline later returns a next-PC tagged with a thread number, and the block stores it as that thread's new PC. The PCs live in a small asynchronous-read RAM addressed by thread number. A per-thread "fresh" flag stands in for a reset of the RAM, so the array itself needs no reset.

Two strap inputs are sampled while reset is low. The first picks the start addresses: either every thread starts at one shared boot address, or thread t starts at the boot address plus t times a fixed stride. The second picks solo boot: only thread 0 runs until software pulses the release input, and then every thread joins the rotation. The thread number goes out with every fetch. Software can learn its identity from it, or from its distinct start address.

Top module: `thread_pc_seq`

## Requirements
- R1: While reset is low, fetch_valid is 0 after every clock edge.
- R2: With strap_split_vec low during reset, the first PC issued for every thread equals BOOT_VEC (default 0x0100).
- R3: With strap_split_vec high during reset, the first PC issued for thread t equals BOOT_VEC + t*STRIDE (default stride 0x0040).
- R4: With strap_solo_boot high during reset, only thread 0 is issued, on every clock, until a release is seen.
- R5: A release_pulse sampled at one edge enables all threads at that edge. The pick made at the following edge already uses the full set, so the new threads appear at the second fetch after the pulse.
- R6: Enabled threads are issued one per clock in ascending thread number, wrapping from N-1 to 0, starting with thread 0 after reset. fetch_valid is 1 on each clock that follows an edge where any thread was enabled, and fetch_tid names the thread whose PC is on fetch_pc.
- R7: A writeback (wb_valid, wb_tid, wb_pc) sets only thread wb_tid's PC. The next time that thread is issued, fetch_pc equals wb_pc, and the PCs of all other threads are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| strap_split_vec | input | 1 | 1: each thread starts at its own address; 0: all threads share BOOT_VEC |
| strap_solo_boot | input | 1 | 1: only thread 0 runs after reset until release |
| wb_valid | input | 1 | Next-PC writeback strobe |
| wb_tid | input | TW | Thread whose PC is written |
| wb_pc | input | PC_W | New PC for that thread |
| release_pulse | input | 1 | Software release; enables every thread |
| fetch_valid | output | 1 | The fetch outputs carry a real issue this cycle |
| fetch_tid | output | TW | Thread being issued |
| fetch_pc | output | PC_W | PC of the issued thread |

## Verification
The bench runs each combination of the straps. It predicts the full sequence of issued threads and PCs, and every thread gets a different PC step on writeback. If the design kept one shared PC, or wrote a writeback into the wrong thread's slot, a thread would show another thread's step. If the design ignored the split strap, the first PCs would collapse to one address. The release sits mid-phase to pin the two-edge latency: a design that enables the threads a cycle early or late shifts the rotation by one slot. A design that lets held threads slip in during solo boot shows a non-zero thread number before release.

// File: rtl/thread_seq_pkg.sv
// Package: types shared by the thread PC sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package thread_seq_pkg;

    // Start-up options captured while reset is held
    typedef struct packed {
        logic split_vec;   // per-thread start addresses
        logic solo_boot;   // only thread 0 runs until release
    } strap_t;

endpackage

// File: rtl/thread_rr_pick.sv
// Round-robin chooser: returns the first enabled thread after `last`,
// searching upward and wrapping. `any` is high if some thread is enabled.
// Assumes: N >= 2; when none are enabled, pick holds `last`.
module thread_rr_pick #(
    parameter int N  = 4,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  en,
    input  logic [TW-1:0] last,
    output logic [TW-1:0] pick,
    output logic          any
);

    // Search the N candidates that follow `last`, nearest first
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = last;
        any   = |en;
        for (int i = 1; i <= N; i++) begin
            if (!found && en[(int'(last) + i) % N]) begin
                pick  = TW'((int'(last) + i) % N);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/thread_pc_bank.sv
// Per-thread PC storage: an unreset asynchronous-read RAM plus a reset
// "fresh" flag per thread. A fresh thread reads its reset vector in place
// of the RAM word, until its first writeback.
// Assumes: one write port and one read port; a read and a write to the same
// thread in one cycle return the old value.
module thread_pc_bank #(
    parameter int          N        = 4,
    parameter int          TW       = $clog2(N),
    parameter int          PC_W     = 16,
    parameter logic [PC_W-1:0] BOOT_VEC = 16'h0100,
    parameter logic [PC_W-1:0] STRIDE   = 16'h0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            split_vec,
    input  logic [TW-1:0]   rd_tid,
    output logic [PC_W-1:0] rd_pc,
    input  logic            wr_en,
    input  logic [TW-1:0]   wr_tid,
    input  logic [PC_W-1:0] wr_pc
);

    logic [PC_W-1:0] mem   [N];
    logic [PC_W-1:0] rvec  [N];
    logic [N-1:0]    fresh;

    // Reset vector of each thread, chosen by the captured strap
    for (genvar t = 0; t < N; t++) begin : g_vec
        localparam logic [PC_W-1:0] OWN_VEC = BOOT_VEC + PC_W'(t) * STRIDE;
        assign rvec[t] = split_vec ? OWN_VEC : BOOT_VEC;
    end

    // RAM write port: store the returned next-PC for one thread
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_tid] <= wr_pc;
    end

    // Fresh flags: set by reset, cleared by that thread's first writeback
    always_ff @(posedge clk) begin
        if (!rst_n)      fresh         <= '1;
        else if (wr_en)  fresh[wr_tid] <= 1'b0;
    end

    // Read port: reset vector until the thread has been written
    assign rd_pc = fresh[rd_tid] ? rvec[rd_tid] : mem[rd_tid];

endmodule

// File: rtl/thread_gate.sv
// Thread enable mask. Reset enables either all threads or only thread 0
// (solo boot). A release pulse enables all of them.
// Assumes: release is a single-cycle strobe; it is sticky until the next reset.
module thread_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         solo_boot,
    input  logic         release_pulse,
    output logic [N-1:0] en_mask
);

    localparam logic [N-1:0] ONLY_BOOT = N'(1);

    // Mask update: reset value from strap, release opens every thread
    always_ff @(posedge clk) begin
        if (!rst_n)             en_mask <= solo_boot ? ONLY_BOOT : '1;
        else if (release_pulse) en_mask <= '1;
    end

endmodule

// File: rtl/thread_pc_seq.sv
// Top: barrel thread PC sequencer. Each clock it issues the next enabled
// thread in rotation, with that thread's PC, and accepts tagged next-PC
// writebacks.
// Assumes: the straps are stable while rst_n is low; N >= 2.
module thread_pc_seq
    import thread_seq_pkg::*;
#(
    parameter int              N        = 4,
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] BOOT_VEC = 16'h0100,
    parameter logic [PC_W-1:0] STRIDE   = 16'h0040,
    localparam int             TW       = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_split_vec,
    input  logic            strap_solo_boot,
    input  logic            wb_valid,
    input  logic [TW-1:0]   wb_tid,
    input  logic [PC_W-1:0] wb_pc,
    input  logic            release_pulse,
    output logic            fetch_valid,
    output logic [TW-1:0]   fetch_tid,
    output logic [PC_W-1:0] fetch_pc
);

    strap_t        straps_q;
    logic [N-1:0]  en_mask;
    logic [TW-1:0] cur_tid;
    logic          cur_vld;
    logic [TW-1:0] nxt_tid;
    logic          nxt_any;

    // Capture the start-up options while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) straps_q <= '{split_vec: strap_split_vec, solo_boot: strap_solo_boot};
    end

    thread_gate #(.N(N)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .solo_boot     (strap_solo_boot),
        .release_pulse (release_pulse),
        .en_mask       (en_mask)
    );

    thread_rr_pick #(.N(N), .TW(TW)) u_pick (
        .en   (en_mask),
        .last (cur_tid),
        .pick (nxt_tid),
        .any  (nxt_any)
    );

    // Issue register: thread chosen for this cycle's fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tid <= TW'(N - 1);
            cur_vld <= 1'b0;
        end else begin
            cur_tid <= nxt_tid;
            cur_vld <= nxt_any;
        end
    end

    thread_pc_bank #(
        .N(N), .TW(TW), .PC_W(PC_W), .BOOT_VEC(BOOT_VEC), .STRIDE(STRIDE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .split_vec (straps_q.split_vec),
        .rd_tid    (cur_tid),
        .rd_pc     (fetch_pc),
        .wr_en     (wb_valid),
        .wr_tid    (wb_tid),
        .wr_pc     (wb_pc)
    );

    assign fetch_valid = cur_vld;
    assign fetch_tid   = cur_tid;

endmodule

// File: rtl/thread_seq_chk.sv
// Checker for thread_pc_seq, attached with bind. It relates the enable mask,
// the writeback and release inputs, and the fetch outputs over time.
module thread_seq_chk #(
    parameter int N    = 4,
    parameter int PC_W = 16,
    parameter int TW   = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wb_valid,
    input logic [TW-1:0]   wb_tid,
    input logic [PC_W-1:0] wb_pc,
    input logic            release_pulse,
    input logic            fetch_valid,
    input logic [TW-1:0]   fetch_tid,
    input logic [PC_W-1:0] fetch_pc,
    input logic [N-1:0]    en_mask
);

    AST_IDLE_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !fetch_valid);                                   // R1

    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (($past(en_mask) >> fetch_tid) & N'(1)) != '0); // R4

    AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> (&en_mask));                              // R5

    AST_ISSUE_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_mask) |=> fetch_valid);                                // R6

    AST_ROTATION_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid) && (&$past(en_mask)))
        |-> fetch_tid == (($past(fetch_tid) == TW'(N - 1)) ? TW'(0)
                                                           : $past(fetch_tid) + TW'(1))); // R6

    AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(rst_n) && $past(wb_valid) && ($past(wb_tid) == fetch_tid))
        |-> fetch_pc == $past(wb_pc));                              // R7

endmodule

bind thread_pc_seq thread_seq_chk #(.N(N), .PC_W(PC_W), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wb_valid      (wb_valid),
    .wb_tid        (wb_tid),
    .wb_pc         (wb_pc),
    .release_pulse (release_pulse),
    .fetch_valid   (fetch_valid),
    .fetch_tid     (fetch_tid),
    .fetch_pc      (fetch_pc),
    .en_mask       (en_mask)
);

// File: tb/sim_thread_pc_seq.sv
module sim_thread_pc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NT   = 4;
    localparam logic [15:0] BOOT = 16'h0100;
    localparam logic [15:0] STEP = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_split_vec = 1'b0;
    logic        strap_solo_boot = 1'b0;
    logic        wb_valid = 1'b0;
    logic [1:0]  wb_tid = '0;
    logic [15:0] wb_pc = '0;
    logic        release_pulse = 1'b0;
    logic        fetch_valid;
    logic [1:0]  fetch_tid;
    logic [15:0] fetch_pc;

    typedef struct {
        logic [1:0]  tid;
        logic [15:0] pc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   mon_on = 1'b0;
    int   obs = 0;
    int   rel_at = -1;

    thread_pc_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .strap_split_vec(strap_split_vec), .strap_solo_boot(strap_solo_boot),
        .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_pc(wb_pc),
        .release_pulse(release_pulse),
        .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver-side predictor: pushes the expected issue sequence of one phase
    task automatic plan(input bit split, input bit solo, input int cycles, input int rel);
        logic [15:0] m[NT];
        bit   seen[NT];
        bit [NT-1:0] en;
        int   last = NT - 1;
        for (int t = 0; t < NT; t++) begin
            m[t]    = split ? BOOT + 16'(t) * STEP : BOOT;
            seen[t] = 1'b0;
        end
        for (int c = 0; c < cycles; c++) begin
            int   j = last;
            bit   got = 1'b0;
            exp_t e;
            if (solo && !(rel >= 0 && c >= rel + 2)) en = 4'b0001;
            else                                      en = 4'b1111;
            for (int i = 1; i <= NT; i++) begin
                if (!got && en[(last + i) % NT]) begin
                    j = (last + i) % NT;
                    got = 1'b1;
                end
            end
            e.tid = 2'(j);
            e.pc  = m[j];
            if (solo && en == 4'b0001)             e.tag = "R4";
            else if (solo && c < rel + 2 + NT)     e.tag = "R5";
            else if (!seen[j])                     e.tag = split ? "R3" : "R2";
            else                                   e.tag = "R6/R7";
            q.push_back(e);
            m[j]    = m[j] + 16'(4 * (j + 1));
            seen[j] = 1'b1;
            last    = j;
        end
    endtask

    // Monitor: pops and compares each cycle, then returns a writeback for the issue
    initial forever begin
        @(negedge clk);
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (fetch_valid !== 1'b1 || fetch_tid !== e.tid || fetch_pc !== e.pc) begin
                bad++;
                $display("FAIL %s: got v=%0b tid=%0d pc=%h expected v=1 tid=%0d pc=%h",
                         e.tag, fetch_valid, fetch_tid, fetch_pc, e.tid, e.pc);
            end
            wb_valid      = fetch_valid;
            wb_tid        = fetch_tid;
            wb_pc         = fetch_pc + 16'(4 * (int'(fetch_tid) + 1));
            release_pulse = (obs == rel_at);
            obs++;
        end
    end

    task automatic run_phase(input bit split, input bit solo, input int cycles, input int rel);
        @(negedge clk);
        rst_n = 1'b0;
        strap_split_vec = split;
        strap_solo_boot = solo;
        wb_valid = 1'b0;
        release_pulse = 1'b0;
        repeat (3) @(negedge clk);
        total++;   // R1: no issue while reset is held
        if (fetch_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: got fetch_valid=%0b expected 0", fetch_valid);
        end
        plan(split, solo, cycles, rel);
        rel_at = rel;
        obs    = 0;
        rst_n  = 1'b1;
        @(posedge clk);
        mon_on = 1'b1;
        wait (q.size() == 0);
        @(posedge clk);
        mon_on = 1'b0;
        wb_valid = 1'b0;
        release_pulse = 1'b0;
    endtask

    initial begin
        run_phase(1'b0, 1'b0, 12, -1);   // R2, R6, R7: shared vector, free rotation
        run_phase(1'b1, 1'b0, 12, -1);   // R3: distinct start addresses
        run_phase(1'b1, 1'b1, 16, 5);    // R4, R5: solo boot then release
        run_phase(1'b0, 1'b1, 6, -1);    // R4: solo boot, never released
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_up();
    end

endmodule